// File: doc/BRIEF.md
# Periodic Wakeup Interrupt Timer

This block raises a flag at a fixed, selectable interval so that a microcontroller can wake from a low-power state, or be interrupted, on a regular schedule. It counts qualified ticks from one of two sources. The first is an internal slow tick at nominally 1 kHz. The second is a tick taken from the external oscillator. A 3-bit period code picks one of seven intervals, and code zero turns the timer off. Both tick sources arrive as single-cycle enable pulses in the block's clock domain.

Software reaches the timer through one 8-bit register port. Bit 7 is the read-only expiry flag. Bit 6 is the write-only acknowledge. Bit 5 picks the source (0 internal, 1 external). Bit 4 is the interrupt enable. Bits 2:0 hold the period code. Bit 3 is unused and reads 0.

The current power mode decides whether the external source may advance the count. The modes are encoded 0 run, 1 wait, 2 light stop and 3 deep stop. The masked flag is presented as an interrupt request. In either stop mode it is also presented as a wakeup request to the power controller.

Top module: `rti_wakeup_timer`

## Requirements
- R1: After reset the register reads 0x00, and both `irq` and `wake_req` are low.
- R2: With period code 0 the counter holds, and the flag never sets.
- R3: With the internal source, codes 1 to 7 set the flag after 8, 32, 64, 128, 256, 512 and 1024 qualified ticks.
- R4: With the external source, codes 1 to 7 set the flag after 256, 1024, 2048, 4096, 8192, 16384 and 32768 qualified ticks.
- R5: The flag (bit 7) sets only on expiry, and writing bit 7 has no effect. Bit 3 always reads 0.
- R6: A register write with bit 6 = 1 clears the flag. Bit 6 always reads 0.
- R7: `irq` equals flag AND enable (bit 4). `wake_req` equals `irq` while the mode is 2 or 3. The flag sets even while the request is masked.
- R8: In modes 0 and 1 the external source always advances the count. In mode 2 it advances only when `osc_stop_en`=1 and `osc_range_hi`=0.
- R9: In mode 3 the external source never advances the count. The internal source still advances it and can raise `wake_req`.
- R10: A write that changes the period code or the source bit restarts the count from zero, so the next interval is a full one.
- R11: If an expiry and an acknowledge write happen in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pm_mode | input | 2 | Power mode: 0 run, 1 wait, 2 light stop, 3 deep stop |
| int_tick | input | 1 | One-cycle pulse from the internal 1 kHz source |
| ext_tick | input | 1 | One-cycle pulse from the external oscillator source |
| osc_stop_en | input | 1 | External oscillator kept running in stop |
| osc_range_hi | input | 1 | External oscillator in high-range mode |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq | output | 1 | Masked interrupt request |
| wake_req | output | 1 | Wakeup request to the power controller |

## Verification
The bench sweeps every internal period code and the shorter external codes. A design with an off-by-one limit compare would measure 7 or 9 ticks instead of 8. It lands an acknowledge on the exact cycle of an expiry. A design that let the clear win would lose that event and show the flag low.

It holds the external source in light stop with each of the two qualifiers wrong, and then in deep stop with both qualifiers right. A design that leaks ticks there would set the flag. A select change is made part-way through an interval. A design without the restart would expire early.

// File: rtl/rti_pkg.sv
package rti_pkg;

    typedef enum logic [1:0] {
        PM_RUN        = 2'd0,
        PM_WAIT       = 2'd1,
        PM_STOP_LIGHT = 2'd2,
        PM_STOP_DEEP  = 2'd3
    } pm_mode_e;

    localparam int FLAG_BIT = 7;
    localparam int ACK_BIT  = 6;
    localparam int CSEL_BIT = 5;
    localparam int IE_BIT   = 4;
    localparam int SEL_W    = 3;

    typedef struct packed {
        logic             flag;
        logic             csel;
        logic             ie;
        logic [SEL_W-1:0] sel;
    } ctrl_s;

endpackage

// File: rtl/rti_src_qual.sv
module rti_src_qual
    import rti_pkg::*;
(
    input  logic [1:0] pm_mode,
    input  logic       csel,
    input  logic       int_tick,
    input  logic       ext_tick,
    input  logic       osc_stop_en,
    input  logic       osc_range_hi,
    output logic       tick_ok
);
    logic ext_allowed;

    always_comb begin
        unique case (pm_mode_e'(pm_mode))
            PM_RUN, PM_WAIT: ext_allowed = 1'b1;
            PM_STOP_LIGHT:   ext_allowed = osc_stop_en & ~osc_range_hi;
            default:         ext_allowed = 1'b0;
        endcase
        tick_ok = csel ? (ext_tick & ext_allowed) : int_tick;
    end
endmodule

// File: rtl/rti_prescaler.sv
module rti_prescaler
    import rti_pkg::*;
#(
    parameter int INT_EXP1 = 3,
    parameter int EXT_EXP1 = 8,
    parameter int CNT_W    = EXT_EXP1 + 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             csel,
    input  logic [SEL_W-1:0] sel,
    input  logic             restart,
    output logic             expire,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;
    int               shamt;
    logic             active;

    always_comb begin
        shamt  = (csel ? EXT_EXP1 : INT_EXP1) + ((sel == SEL_W'(1)) ? 0 : int'(sel));
        limit  = (CNT_W'(1) << shamt) - CNT_W'(1);
        active = tick && (sel != '0) && !restart;
        expire = active && (cnt_q == limit);
        cnt_d  = cnt_q;
        if (restart)
            cnt_d = '0;
        else if (active)
            cnt_d = expire ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/rti_wakeup_timer.sv
module rti_wakeup_timer
    import rti_pkg::*;
#(
    parameter int INT_EXP1 = 3,
    parameter int EXT_EXP1 = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pm_mode,
    input  logic       int_tick,
    input  logic       ext_tick,
    input  logic       osc_stop_en,
    input  logic       osc_range_hi,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       wake_req
);
    localparam int CNT_W = EXT_EXP1 + 7;

    ctrl_s            r_d, r_q;
    logic             tick_ok;
    logic             restart;
    logic             expire_w;
    logic [CNT_W-1:0] pre_cnt;
    logic             unused_wbits;

    assign unused_wbits = ^{reg_wdata[FLAG_BIT], reg_wdata[3]};

    rti_src_qual u_qual (
        .pm_mode      (pm_mode),
        .csel         (r_q.csel),
        .int_tick     (int_tick),
        .ext_tick     (ext_tick),
        .osc_stop_en  (osc_stop_en),
        .osc_range_hi (osc_range_hi),
        .tick_ok      (tick_ok)
    );

    rti_prescaler #(
        .INT_EXP1 (INT_EXP1),
        .EXT_EXP1 (EXT_EXP1),
        .CNT_W    (CNT_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_ok),
        .csel    (r_q.csel),
        .sel     (r_q.sel),
        .restart (restart),
        .expire  (expire_w),
        .cnt     (pre_cnt)
    );

    always_comb begin
        r_d     = r_q;
        restart = reg_wr && ((reg_wdata[SEL_W-1:0] != r_q.sel) ||
                             (reg_wdata[CSEL_BIT] != r_q.csel));
        if (expire_w)
            r_d.flag = 1'b1;
        else if (reg_wr && reg_wdata[ACK_BIT])
            r_d.flag = 1'b0;
        if (reg_wr) begin
            r_d.csel = reg_wdata[CSEL_BIT];
            r_d.ie   = reg_wdata[IE_BIT];
            r_d.sel  = reg_wdata[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign reg_rdata = {r_q.flag, 1'b0, r_q.csel, r_q.ie, 1'b0, r_q.sel};
    assign irq       = r_q.flag & r_q.ie;
    assign wake_req  = irq & pm_mode[1];
endmodule

// File: rtl/rti_wakeup_timer_chk.sv
module rti_wakeup_timer_chk #(
    parameter int CNT_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       pm_mode,
    input logic             osc_stop_en,
    input logic             reg_wr,
    input logic             ack_wr,
    input logic [7:0]       reg_rdata,
    input logic             irq,
    input logic             wake_req,
    input logic [CNT_W-1:0] cnt,
    input logic             expire
);
    AST_SEL0_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[2:0] == 3'd0 && !reg_rdata[7]) |=> !reg_rdata[7]); // R2

    AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[6] == 1'b0) && (reg_rdata[3] == 1'b0)); // R6

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !expire) |=> !reg_rdata[7]); // R6

    AST_EXPIRY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> reg_rdata[7]); // R11

    AST_MASKED_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[4] |-> !irq); // R7

    AST_WAKE_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (irq && pm_mode[1])); // R7

    AST_LIGHT_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_mode == 2'd2 && reg_rdata[5] && !osc_stop_en && !reg_wr) |=> $stable(cnt)); // R8

    AST_DEEP_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_mode == 2'd3 && reg_rdata[5] && !reg_wr) |=> $stable(cnt)); // R9
endmodule

bind rti_wakeup_timer rti_wakeup_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pm_mode     (pm_mode),
    .osc_stop_en (osc_stop_en),
    .reg_wr      (reg_wr),
    .ack_wr      (reg_wr & reg_wdata[6]),
    .reg_rdata   (reg_rdata),
    .irq         (irq),
    .wake_req    (wake_req),
    .cnt         (pre_cnt),
    .expire      (expire_w)
);

// File: tb/rti_wakeup_timer_tb.sv
module rti_wakeup_timer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pm_mode = 2'd0;
    logic       int_tick = 1'b1;
    logic       ext_tick = 1'b1;
    logic       osc_stop_en = 1'b0;
    logic       osc_range_hi = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq, wake_req;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rti_wakeup_timer dut_i (
        .clk(clk), .rst_n(rst_n), .pm_mode(pm_mode), .int_tick(int_tick),
        .ext_tick(ext_tick), .osc_stop_en(osc_stop_en), .osc_range_hi(osc_range_hi),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .wake_req(wake_req)
    );

    function automatic int period_of(input bit ext, input int code);
        int tbl_i[8] = '{0, 8, 32, 64, 128, 256, 512, 1024};
        int tbl_e[8] = '{0, 256, 1024, 2048, 4096, 8192, 16384, 32768};
        return ext ? tbl_e[code] : tbl_i[code];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // behavioural reference model
    bit m_flag, m_csel, m_ie;
    int m_sel, m_cnt;
    always @(posedge clk) begin
        bit ext_ok, tok, rs, ex;
        if (!rst_n) begin
            m_flag = 0; m_csel = 0; m_ie = 0; m_sel = 0; m_cnt = 0;
        end else begin
            ext_ok = (pm_mode < 2) || (pm_mode == 2 && osc_stop_en && !osc_range_hi);
            tok    = m_csel ? (ext_tick && ext_ok) : int_tick;
            rs     = reg_wr && ((int'(reg_wdata[2:0]) != m_sel) || (reg_wdata[5] != m_csel));
            ex     = !rs && m_sel != 0 && tok && (m_cnt + 1 == period_of(m_csel, m_sel));
            if (rs) m_cnt = 0;
            else if (tok && m_sel != 0) m_cnt = ex ? 0 : m_cnt + 1;
            if (ex) m_flag = 1;
            else if (reg_wr && reg_wdata[6]) m_flag = 0;
            if (reg_wr) begin
                m_csel = reg_wdata[5]; m_ie = reg_wdata[4]; m_sel = int'(reg_wdata[2:0]);
            end
        end
    end

    initial forever begin
        logic [7:0] erd;
        @(posedge clk);
        #(CLK_PERIOD/4);
        erd = {m_flag, 1'b0, m_csel, m_ie, 1'b0, 3'(m_sel)};
        chk(reg_rdata[7] == erd[7], "R5 flag vs model", reg_rdata[7], erd[7]);
        chk(reg_rdata == erd, "R1 register vs model", reg_rdata, erd);
        chk(irq == (m_flag & m_ie), "R7 irq vs model", irq, m_flag & m_ie);
        chk(wake_req == (m_flag & m_ie & pm_mode[1]), "R7 wake vs model",
            wake_req, m_flag & m_ie & pm_mode[1]);
    end

    task automatic wr(input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic measure(output int n);
        n = 0;
        while (n < 40000) begin
            @(posedge clk); #1; n++;
            if (reg_rdata[7]) break;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        #1;
        chk(reg_rdata == 8'h00, "R1 reset register", reg_rdata, 0);
        chk(!irq && !wake_req, "R1 reset outputs", {irq, wake_req}, 0);
        rst_n = 1'b1;

        // R2: code 0 never expires
        wr(8'h50);
        repeat (3000) @(negedge clk);
        chk(reg_rdata[7] == 1'b0, "R2 off code flag", reg_rdata[7], 0);

        // R3: internal period sweep
        for (int c = 1; c <= 7; c++) begin
            wr(8'h50 | 8'(c));
            measure(n);
            chk(n == period_of(0, c), "R3 internal period", n, period_of(0, c));
        end

        // R6: ack clears and reads 0 (ticks stopped, no restart)
        int_tick = 1'b0;
        wr(8'h57);
        #1;
        chk(reg_rdata[7] == 1'b0, "R6 ack clears", reg_rdata[7], 0);
        chk(reg_rdata[6] == 1'b0, "R6 ack reads zero", reg_rdata[6], 0);
        // R5: writing bit 7 does not set the flag
        wr(8'h97);
        #1;
        chk(reg_rdata[7] == 1'b0, "R5 flag write ignored", reg_rdata[7], 0);
        chk(reg_rdata[3] == 1'b0, "R5 bit3 reads zero", reg_rdata[3], 0);
        int_tick = 1'b1;

        // R7: masked flag still sets
        wr(8'h41);
        measure(n);
        chk(n == 8 && irq == 1'b0, "R7 masked flag", irq, 0);
        wr(8'h11);
        #1;
        chk(irq == 1'b1, "R7 irq unmasked", irq, 1);

        // R11: ack on the expiry cycle
        wr(8'h52);
        wr(8'h51);
        repeat (7) @(posedge clk);
        wr(8'h51);
        #1;
        chk(reg_rdata[7] == 1'b1, "R11 expiry beats ack", reg_rdata[7], 1);

        // R10: change code mid interval
        wr(8'h52);
        repeat (20) @(negedge clk);
        wr(8'h51);
        measure(n);
        chk(n == 8, "R10 restart on code change", n, 8);

        // R4: external period sweep (run and wait)
        for (int c = 1; c <= 3; c++) begin
            pm_mode = (c == 2) ? 2'd1 : 2'd0;
            wr(8'h70 | 8'(c));
            measure(n);
            chk(n == period_of(1, c), "R4 external period", n, period_of(1, c));
        end

        // R8: light stop qualification
        pm_mode = 2'd2; osc_stop_en = 1'b0; osc_range_hi = 1'b0;
        wr(8'h71);
        repeat (600) @(negedge clk);
        chk(reg_rdata[7] == 1'b0, "R8 stop without enable", reg_rdata[7], 0);
        osc_stop_en = 1'b1; osc_range_hi = 1'b1;
        repeat (600) @(negedge clk);
        chk(reg_rdata[7] == 1'b0, "R8 stop high range", reg_rdata[7], 0);
        osc_range_hi = 1'b0;
        measure(n);
        chk(n == 256, "R8 stop qualified", n, 256);

        // R9: deep stop
        pm_mode = 2'd3;
        wr(8'h52);
        wr(8'h71);
        repeat (600) @(negedge clk);
        chk(reg_rdata[7] == 1'b0, "R9 deep stop external held", reg_rdata[7], 0);
        wr(8'h51);
        measure(n);
        chk(n == 8, "R9 deep stop internal period", n, 8);
        chk(wake_req == 1'b1, "R9 deep stop wake", wake_req, 1);

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule